// File: doc/BRIEF.md
# I2C Receive Interrupt and SCL Stretch Controller

This block sits in the receive path of an I2C controller. It counts SCL falling edges within each byte and decides when to stretch SCL low and raise a byte interrupt. Start and stop detection, the shift register and clock generation live elsewhere. Their results reach this block as single-cycle strobes.

The block keeps two hold flags. The main flag is cleared only by the transfer logic and is released by a resume strobe. The secondary flag can be forced low or released by software. SCL is stretched while either flag is 0.

With the early-interrupt mode enabled and an acknowledge clock in use, the block adds a stretch and interrupt after the last data clock, before the acknowledge clock. This gives software time to look at the received data before it chooses the acknowledge value. The byte-end interrupt still follows.

A small control register holds the mode bit and three write-one action bits. The action bits release the secondary flag, force the secondary flag low, and clear the STOP flag.

Top module: `i2c_rx_hold_ctl`

## Requirements
- R1: After reset the main and secondary hold flags are 1, SCL is not held, irq is 0, the STOP flag is 0 and the register reads 0x00.
- R2: With the mode bit (register bit 0) at 0 and ack_clk=1, the ninth scl_fall of a byte clears the main flag, holds SCL and gives a one-cycle irq in the next cycle; falls one to eight give no irq.
- R3: With ack_clk=0 a byte has eight clocks: the eighth scl_fall clears the main flag and raises irq.
- R4: With the mode bit at 1 and ack_clk=1, the eighth scl_fall clears the secondary flag and raises irq, and the ninth fall still clears the main flag and raises irq.
- R5: With the mode bit at 1 and ack_clk=0 there is no early interrupt: the eighth fall is the byte end, and the secondary flag stays 1.
- R6: scl_hold is 1 whenever either flag is 0, and 0 once both are 1.
- R7: The main flag returns to 1 only on a resume pulse. No register write changes it.
- R8: A write with bit 5 set sets the secondary flag to 1; a write with bit 5 clear leaves it unchanged.
- R9: A write with bit 6 set clears the secondary flag and holds SCL; if bits 5 and 6 are both set, the set-to-1 action wins.
- R10: stop_det sets the STOP flag; a write with bit 4 set clears it; a write with bit 4 clear does not.
- R11: Reads return the mode bit at bit 0; the action bits and all unused bits read 0.
- R12: byte_start restarts the clock count, so the next byte ends on its own full count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_start | input | 1 | Strobe: a new byte begins, count restarts |
| scl_fall | input | 1 | Strobe: SCL falling edge seen |
| ack_clk | input | 1 | 1 when the byte includes an acknowledge clock |
| resume | input | 1 | Software resume strobe, sets the main flag |
| stop_det | input | 1 | Strobe: STOP condition detected |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| hold_main | output | 1 | Main hold flag (0 = holding) |
| hold_sec | output | 1 | Secondary hold flag (0 = holding) |
| scl_hold | output | 1 | Drive SCL low |
| irq | output | 1 | One-cycle interrupt request |
| stop_flag | output | 1 | STOP condition flag |

## Verification
The bench counts edges in every mode and acknowledge-clock combination. A miscount of one would put the interrupt on the wrong fall, or would leave out or duplicate the early interrupt. The bench writes both secondary action bits at once. A wrong priority shows up as SCL staying stretched. It also tries register writes and an early release against the main flag: a design that let software touch that flag would release SCL too soon. Finally, it aborts a byte halfway with byte_start, which catches a counter that carries the partial count into the next byte.

// File: rtl/i2c_rx_hold_ctl.sv
module i2c_rx_hold_ctl #(
  parameter int DATA_BITS = 8,
  parameter int REG_W     = 8,
  parameter int MODE_BIT  = 0,
  parameter int STOPC_BIT = 4,
  parameter int REL_BIT   = 5,
  parameter int FORCE_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_start,
  input  logic             scl_fall,
  input  logic             ack_clk,
  input  logic             resume,
  input  logic             stop_det,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             hold_main,
  output logic             hold_sec,
  output logic             scl_hold,
  output logic             irq,
  output logic             stop_flag
);
  localparam int CW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(DATA_BITS - 1);
  localparam logic [CW-1:0] ACK_SLOT  = CW'(DATA_BITS);

  logic [CW-1:0] cnt;
  logic          early_mode;

  wire           wr_rel   = reg_wr && reg_wdata[REL_BIT];
  wire           wr_force = reg_wr && reg_wdata[FORCE_BIT];
  wire           wr_stopc = reg_wr && reg_wdata[STOPC_BIT];
  wire [CW-1:0]  last_cnt = ack_clk ? ACK_SLOT : LAST_DATA;
  wire           byte_end = scl_fall && (cnt == last_cnt);
  wire           early    = scl_fall && early_mode && ack_clk && (cnt == LAST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (byte_start) cnt <= '0;
    else if (byte_end) cnt <= '0;
    else if (scl_fall) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) early_mode <= 1'b0;
    else if (reg_wr) early_mode <= reg_wdata[MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_main <= 1'b1;
    else if (byte_end) hold_main <= 1'b0;
    else if (resume) hold_main <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_sec <= 1'b1;
    else if (early) hold_sec <= 1'b0;
    else if (wr_rel) hold_sec <= 1'b1;
    else if (wr_force) hold_sec <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_flag <= 1'b0;
    else if (stop_det) stop_flag <= 1'b1;
    else if (wr_stopc) stop_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= byte_end || early;
  end

  assign scl_hold = !(hold_main && hold_sec);

  always_comb begin
    reg_rdata = '0;
    reg_rdata[MODE_BIT] = early_mode;
  end

  // R6
  irq_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_hold);

  // R7
  main_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_main) |-> $past(resume));

  // R2
  main_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_main) |-> ($past(scl_fall) && irq));

  // R9
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_sec) |-> ($past(scl_fall) || $past(wr_force)));

  // R8
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_sec) |-> $past(wr_rel));

  // R10
  stop_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(stop_det));

  // R11
  rd_action_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[REL_BIT] == 1'b0) && (reg_rdata[FORCE_BIT] == 1'b0) && (reg_rdata[STOPC_BIT] == 1'b0));
endmodule

// File: tb/sim_i2c_rx_hold_ctl.sv
module sim_i2c_rx_hold_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_start = 1'b0, scl_fall = 1'b0, ack_clk = 1'b1;
  logic resume = 1'b0, stop_det = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic hold_main, hold_sec, scl_hold, irq, stop_flag;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_rx_hold_ctl u0 (
    .clk(clk), .rst_n(rst_n), .byte_start(byte_start), .scl_fall(scl_fall),
    .ack_clk(ack_clk), .resume(resume), .stop_det(stop_det), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hold_main(hold_main),
    .hold_sec(hold_sec), .scl_hold(scl_hold), .irq(irq), .stop_flag(stop_flag));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fall(output bit irq_seen);
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    irq_seen = irq;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = d; end
    @(negedge clk) begin reg_wr = 1'b0; reg_wdata = '0; end
  endtask

  task automatic pulse_resume;
    @(negedge clk) resume = 1'b1;
    @(negedge clk) resume = 1'b0;
  endtask

  task automatic new_byte;
    @(negedge clk) byte_start = 1'b1;
    @(negedge clk) byte_start = 1'b0;
  endtask

  // runs n falls; returns a mask of which fall (1-based bit) gave irq
  task automatic run_falls(input int n, output int mask);
    bit s;
    mask = 0;
    for (int i = 1; i <= n; i++) begin
      fall(s);
      if (s) mask |= (1 << i);
    end
  endtask

  task automatic t_reset;
    chk("R1 hold_main", hold_main, 1);
    chk("R1 hold_sec", hold_sec, 1);
    chk("R1 scl_hold", scl_hold, 0);
    chk("R1 irq", irq, 0);
    chk("R1 stop_flag", stop_flag, 0);
    chk("R1 rdata", reg_rdata, 0);
  endtask

  task automatic t_mode0_ack;
    int m;
    wr(8'h00); ack_clk = 1'b1; new_byte();
    run_falls(8, m);
    chk("R2 no irq on falls 1-8", m, 0);
    chk("R2 no hold before ninth", scl_hold, 0);
    run_falls(1, m);
    chk("R2 irq on ninth", m, 2);
    chk("R2 main cleared", hold_main, 0);
    chk("R6 scl held", scl_hold, 1);
    @(negedge clk);
    chk("R2 irq one cycle", irq, 0);
    wr(8'hF0);
    chk("R7 write leaves main", hold_main, 0);
    pulse_resume();
    chk("R7 resume sets main", hold_main, 1);
    chk("R6 released", scl_hold, 0);
  endtask

  task automatic t_mode0_noack;
    int m;
    wr(8'h00); ack_clk = 1'b0; new_byte();
    run_falls(8, m);
    chk("R3 irq on eighth only", m, 1 << 8);
    chk("R3 main cleared", hold_main, 0);
    pulse_resume();
  endtask

  task automatic t_mode1_ack;
    int m;
    wr(8'h01); ack_clk = 1'b1; new_byte();
    chk("R11 mode readback", reg_rdata, 1);
    run_falls(8, m);
    chk("R4 early irq on eighth", m, 1 << 8);
    chk("R4 sec cleared", hold_sec, 0);
    chk("R4 main still set", hold_main, 1);
    chk("R6 held by sec", scl_hold, 1);
    pulse_resume();
    chk("R6 resume does not release sec", scl_hold, 1);
    wr(8'h01 | 8'h20);
    chk("R8 release sets sec", hold_sec, 1);
    chk("R6 released after early", scl_hold, 0);
    run_falls(1, m);
    chk("R4 byte-end irq on ninth", m, 2);
    chk("R4 main cleared", hold_main, 0);
    pulse_resume();
  endtask

  task automatic t_mode1_noack;
    int m;
    wr(8'h01); ack_clk = 1'b0; new_byte();
    run_falls(8, m);
    chk("R5 only byte-end irq", m, 1 << 8);
    chk("R5 sec stays", hold_sec, 1);
    chk("R5 main cleared", hold_main, 0);
    pulse_resume();
  endtask

  task automatic t_sw_sec;
    wr(8'h00);
    wr(8'h40);
    chk("R9 force clears sec", hold_sec, 0);
    chk("R9 scl held", scl_hold, 1);
    wr(8'h00);
    chk("R8 zero write no set", hold_sec, 0);
    wr(8'h20);
    chk("R8 set", hold_sec, 1);
    wr(8'h00);
    chk("R9 zero write no clear", hold_sec, 1);
    wr(8'h40);
    wr(8'h60);
    chk("R9 both bits set wins", hold_sec, 1);
    chk("R11 action bits read 0", reg_rdata, 0);
    chk("R7 writes leave main", hold_main, 1);
  endtask

  task automatic t_stop;
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
    chk("R10 stop set", stop_flag, 1);
    wr(8'h00);
    chk("R10 zero write keeps", stop_flag, 1);
    wr(8'h10);
    chk("R10 clear", stop_flag, 0);
  endtask

  task automatic t_restart;
    int m;
    wr(8'h00); ack_clk = 1'b1; new_byte();
    run_falls(4, m);
    new_byte();
    run_falls(8, m);
    chk("R12 no early end after restart", m, 0);
    run_falls(1, m);
    chk("R12 end on ninth after restart", m, 2);
    pulse_resume();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_ack();
    t_mode0_noack();
    t_mode1_ack();
    t_mode1_noack();
    t_sw_sec();
    t_stop();
    t_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule